// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is a slave on a two-wire serial bus (clock line plus open-drain data line) that fronts a 512-byte storage array. It finds START and STOP conditions on the bus. After each START it takes in an address byte. The upper nibble of that byte is a fixed device type. Two bits must match a strap input. One bit gives the ninth memory address bit, and the last bit chooses read or write. The slave pulls the data line low to acknowledge, and only ever pulls it low: the pad releases the line whenever `sda_oe` is low.

A write carries one word-address byte and then data bytes. The data bytes go into a 16-entry page buffer, and the buffer pointer steps through the low four address bits, wrapping inside the page. A STOP after at least one data byte opens a timed busy window of `BUSY_CYCLES` system clocks. During that window the slave stays off the bus, and at the end of it the buffered bytes are written to the array. A read sends bytes most significant bit first and steps through the whole 9-bit address. It continues while the master acknowledges and stops once the master does not acknowledge.

A random read is built from an address-only write (START, address byte, word address), then a repeated START and a read address byte. A repeated START throws away any page data not yet written.

Top module: `twowire_eeprom_slave`

## Requirements
- R1: During and after reset `sda_oe` is low, the slave is idle and every array byte reads as 0x00.
- R2: A repeated START at any bit position returns the slave to address-byte reception and discards buffered write data; the following address byte is decoded normally.
- R3: An address byte is acknowledged (SDA pulled low during the ninth clock) only when its bits 7:4 equal 4'b1010 and its bits 3:2 equal `bus_sel`; any other address byte gets no acknowledge.
- R4: In a write, bit 1 of the address byte becomes memory address bit 8, the next byte sets address bits 7:0, and the slave acknowledges the word address and every data byte.
- R5: Each data byte goes to the page buffer at the current low 4 address bits, which then increment modulo 16; bits 8:4 never change, so a 17th or later byte overwrites an earlier byte of the same transaction.
- R6: A write ended by STOP with no data byte writes nothing and starts no busy window, so the next address byte is acknowledged at once.
- R7: A STOP after one or more data bytes opens a busy window of exactly `BUSY_CYCLES` clocks in which the slave acknowledges nothing and leaves SDA released; the buffered bytes reach the array when the window ends.
- R8: A read sends the byte at the current address MSB first, then increments the full 9-bit address, rolling over from 511 to 0, and keeps sending while the master acknowledges.
- R9: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing until the next START or STOP.
- R10: The slave never begins pulling SDA low while SCL stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which samples the bus and times the busy window |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 2 | Strap value that address bits 3:2 must match |
| scl | input | 1 | Bus clock line |
| sda_in | input | 1 | Data line as seen on the wire |
| sda_oe | output | 1 | When high, the pad pulls the data line low |

## Verification
The bench sends a page write that starts two bytes before the end of a page and carries 20 bytes. A design that carried into bit 4, or that wrote bytes one at a time without wrapping, would leave wrong data in the page or overwrite the next page. It probes the slave straight after a data write, after an address-only write and after a write cut short by a repeated START. A design that got the busy rule wrong would either answer while busy, or lock itself out when nothing was written, or commit data it should have dropped. Sequential reads across 511→0 and a master NACK followed by further clocks expose a read pointer that stalls or fails to wrap, and a slave that keeps driving after it has been told to stop.

// File: rtl/twowire_eeprom_slave.sv
module twowire_eeprom_slave #(
  parameter int MEM_BYTES = 512,
  parameter int PAGE_BYTES = 16,
  parameter int BUSY_CYCLES = 1000,
  parameter logic [3:0] DEV_TYPE = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_sel,
  input  logic       scl,
  input  logic       sda_in,
  output logic       sda_oe
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_WORD, S_WDATA, S_RDATA, S_HOLD} st_t;

  logic [1:0] scl_s, sda_s;
  logic       scl_p, sda_p, scl_q, sda_q;
  logic       start_ev, stop_ev, scl_rise, scl_fall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= 2'b11; sda_s <= 2'b11; scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl};
      sda_s <= {sda_s[0], sda_in};
      scl_p <= scl_s[1];
      sda_p <= sda_s[1];
    end

  assign scl_q    = scl_s[1];
  assign sda_q    = sda_s[1];
  assign start_ev = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_ev  = scl_q & scl_p & ~sda_p & sda_q;
  assign scl_rise = scl_q & ~scl_p;
  assign scl_fall = ~scl_q & scl_p;

  st_t                  st;
  logic [3:0]           bitcnt;
  logic                 ack_slot, acked, rw, rnack, drv, busy;
  logic [7:0]           shreg, txreg;
  logic [AW-1:0]        addr;
  logic [PAGE_BYTES-1:0] pmask;
  logic [CW-1:0]        bcnt;
  logic [7:0]           mem [MEM_BYTES];
  logic [7:0]           pbuf [PAGE_BYTES];
  logic [7:0]           mem_rd;
  logic                 active, byte_end, buf_we, commit;

  assign mem_rd   = mem[addr];
  assign active   = !busy && !start_ev && !stop_ev;
  assign byte_end = active && scl_fall && !ack_slot && bitcnt == 4'd8;
  assign buf_we   = byte_end && st == S_WDATA;
  assign commit   = busy && bcnt == CW'(1);
  assign sda_oe   = drv;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; bitcnt <= '0; ack_slot <= 1'b0; acked <= 1'b0; rw <= 1'b0;
      rnack <= 1'b0; drv <= 1'b0; busy <= 1'b0; shreg <= '0; txreg <= '0;
      addr <= '0; pmask <= '0; bcnt <= '0;
    end else if (busy) begin
      drv <= 1'b0;
      st  <= S_IDLE;
      bcnt <= bcnt - CW'(1);
      if (commit) begin
        busy  <= 1'b0;
        pmask <= '0;
      end
    end else if (start_ev) begin
      st <= S_DEV; bitcnt <= '0; ack_slot <= 1'b0; drv <= 1'b0; pmask <= '0;
    end else if (stop_ev) begin
      st <= S_IDLE; ack_slot <= 1'b0; drv <= 1'b0;
      if (|pmask) begin
        busy <= 1'b1;
        bcnt <= CW'(BUSY_CYCLES);
      end
    end else if (st != S_IDLE && st != S_HOLD) begin
      if (scl_rise) begin
        if (ack_slot) begin
          if (st == S_RDATA) rnack <= sda_q;
        end else if (bitcnt != 4'd8) begin
          bitcnt <= bitcnt + 4'd1;
          if (st != S_RDATA) shreg <= {shreg[6:0], sda_q};
        end
      end else if (scl_fall) begin
        if (ack_slot) begin
          ack_slot <= 1'b0;
          bitcnt   <= '0;
          drv      <= 1'b0;
          case (st)
            S_DEV: begin
              if (!acked) st <= S_HOLD;
              else if (rw) begin
                st <= S_RDATA; txreg <= mem_rd; drv <= ~mem_rd[7];
              end else st <= S_WORD;
            end
            S_WORD: st <= S_WDATA;
            S_RDATA: begin
              if (rnack) st <= S_HOLD;
              else begin
                txreg <= mem_rd; drv <= ~mem_rd[7];
              end
            end
            default: ;
          endcase
        end else if (bitcnt == 4'd8) begin
          ack_slot <= 1'b1;
          case (st)
            S_DEV: begin
              acked <= (shreg[7:4] == DEV_TYPE) && (shreg[3:2] == bus_sel);
              drv   <= (shreg[7:4] == DEV_TYPE) && (shreg[3:2] == bus_sel);
              if ((shreg[7:4] == DEV_TYPE) && (shreg[3:2] == bus_sel)) begin
                rw <= shreg[0];
                addr[AW-1] <= shreg[1];
              end
            end
            S_WORD: begin
              drv <= 1'b1;
              addr[AW-2:0] <= shreg[AW-2:0];
            end
            S_WDATA: begin
              drv <= 1'b1;
              pmask[addr[PW-1:0]] <= 1'b1;
              addr[PW-1:0] <= addr[PW-1:0] + PW'(1);
            end
            S_RDATA: begin
              drv  <= 1'b0;
              addr <= addr + AW'(1);
            end
            default: ;
          endcase
        end else if (st == S_RDATA && bitcnt != 4'd0) begin
          txreg <= {txreg[6:0], 1'b0};
          drv   <= ~txreg[6];
        end
      end
    end

  always_ff @(posedge clk)
    if (buf_we) pbuf[addr[PW-1:0]] <= shreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= '0;
    end else if (commit) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (pmask[i]) mem[{addr[AW-1:PW], PW'(i)}] <= pbuf[i];
    end
endmodule

module twowire_eeprom_slave_chk #(
  parameter int CW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_q,
  input logic          sda_oe,
  input logic          busy,
  input logic [CW-1:0] bcnt
);
  always_ff @(posedge clk)
    if (!rst_n) AST_RESET_QUIET: assert (!sda_oe); // R1

  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe); // R7

  AST_BUSY_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (bcnt == $past(bcnt) - CW'(1))); // R7

  AST_BUSY_LAST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bcnt == CW'(1)) |=> !busy); // R7

  AST_NO_PULL_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q && $past(scl_q)) |-> !$rose(sda_oe)); // R10
endmodule

bind twowire_eeprom_slave twowire_eeprom_slave_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_q(scl_s[1]), .sda_oe(sda_oe),
  .busy(busy), .bcnt(bcnt)
);

// File: tb/sim_twowire_eeprom_slave.sv
`timescale 1ns/1ps
module sim_twowire_eeprom_slave;
  localparam int BUSY = 1000;
  localparam int Q = 6;
  localparam logic [1:0] BUS = 2'b10;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;
  logic [7:0] model [512];

  always #2 clk = ~clk;

  twowire_eeprom_slave #(.BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(BUS), .scl(scl), .sda_in(sda_line), .sda_oe(sda_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    tick(Q); sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b0;
  endtask

  task automatic bus_stop;
    tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic clk_bit(input logic b, output logic r);
    tick(Q); sda_m = b; tick(Q); scl = 1'b1; tick(Q); r = sda_line; tick(Q); scl = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] d, output bit ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], r);
    clk_bit(1'b1, r);
    ack = !r;
  endtask

  task automatic read_byte(input bit give_ack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, r);
      d[i] = r;
    end
    clk_bit(give_ack ? 1'b0 : 1'b1, r);
  endtask

  function automatic logic [7:0] dev(input bit rd, input bit a8);
    return {4'b1010, BUS, a8, rd};
  endfunction

  task automatic probe(input bit exp_ack, input string req);
    bit ack;
    bus_start;
    write_byte(dev(1'b0, 1'b0), ack);
    bus_stop;
    check(ack == exp_ack, req, ack, exp_ack);
  endtask

  task automatic t_random_read(input int a, input int n, input string req);
    bit ack;
    logic [7:0] d;
    bus_start;
    write_byte(dev(1'b0, a[8]), ack);
    write_byte(a[7:0], ack);
    bus_start;
    write_byte(dev(1'b1, a[8]), ack);
    check(ack, "R3 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      read_byte(i != n - 1, d);
      check(d == model[(a + i) % 512], req, d, model[(a + i) % 512]);
    end
    bus_stop;
  endtask

  task automatic t_reset;
    tick(5);
    check(sda_oe == 1'b0, "R1 sda_oe in reset", sda_oe, 0);
    rst_n = 1'b1;
    tick(5);
    check(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
    t_random_read(9'h155, 2, "R1 array cleared");
  endtask

  task automatic t_addr_match;
    bit ack;
    bus_start; write_byte(8'b1011_1000, ack); bus_stop;
    check(!ack, "R3 wrong device type nack", ack, 0);
    bus_start; write_byte({4'b1010, ~BUS, 2'b00}, ack); bus_stop;
    check(!ack, "R3 wrong bus select nack", ack, 0);
    bus_start; write_byte(dev(1'b0, 1'b0), ack); bus_stop;
    check(ack, "R3 matching address ack", ack, 1);
  endtask

  task automatic t_byte_write(input int a, input logic [7:0] v);
    bit a1, a2, a3;
    bus_start;
    write_byte(dev(1'b0, a[8]), a1);
    write_byte(a[7:0], a2);
    write_byte(v, a3);
    bus_stop;
    check(a1 && a2 && a3, "R4 byte write acks", {a1, a2, a3}, 3'b111);
    model[a] = v;
    probe(1'b0, "R7 no ack while busy");
    tick(BUSY);
    probe(1'b1, "R7 ack after busy window");
  endtask

  task automatic t_page_write;
    bit ack, all_ack;
    int off;
    all_ack = 1'b1;
    bus_start;
    write_byte(dev(1'b0, 1'b0), ack); all_ack &= ack;
    write_byte(8'h3E, ack); all_ack &= ack;
    off = 14;
    for (int i = 0; i < 20; i++) begin
      write_byte(8'h60 + 8'(i), ack); all_ack &= ack;
      model[9'h030 + off] = 8'h60 + 8'(i);
      off = (off + 1) % 16;
    end
    bus_stop;
    check(all_ack, "R4 page write acks", all_ack, 1);
    tick(BUSY + 50);
    t_random_read(9'h030, 17, "R5 page wrap contents");
  endtask

  task automatic t_addr_only;
    bit ack;
    bus_start;
    write_byte(dev(1'b0, 1'b1), ack);
    write_byte(8'h20, ack);
    bus_stop;
    probe(1'b1, "R6 no busy after address-only write");
    t_random_read(9'h120, 1, "R6 address-only write leaves data");
  endtask

  task automatic t_restart_discard;
    bit ack;
    logic [7:0] d;
    bus_start;
    write_byte(dev(1'b0, 1'b0), ack);
    write_byte(8'h40, ack);
    write_byte(8'hAA, ack);
    bus_start;
    write_byte(dev(1'b1, 1'b0), ack);
    read_byte(1'b0, d);
    bus_stop;
    check(d == model[9'h041], "R2 restart read at next address", d, model[9'h041]);
    probe(1'b1, "R2 discarded write starts no busy");
    t_random_read(9'h040, 1, "R2 discarded byte not written");
  endtask

  task automatic t_midbyte_restart;
    bit ack;
    logic r;
    bus_start;
    clk_bit(1'b1, r); clk_bit(1'b0, r); clk_bit(1'b1, r); clk_bit(1'b0, r);
    bus_start;
    write_byte(dev(1'b0, 1'b0), ack);
    bus_stop;
    check(ack, "R2 restart mid-byte then address ack", ack, 1);
  endtask

  task automatic t_nack_read;
    bit ack;
    logic [7:0] d;
    bus_start;
    write_byte(dev(1'b0, 1'b1), ack);
    write_byte(8'hA5, ack);
    bus_start;
    write_byte(dev(1'b1, 1'b1), ack);
    read_byte(1'b0, d);
    check(d == model[9'h1A5], "R8 read after nack setup", d, model[9'h1A5]);
    read_byte(1'b0, d);
    check(d == 8'hFF, "R9 released after master nack", d, 8'hFF);
    bus_stop;
  endtask

  initial begin
    for (int i = 0; i < 512; i++) model[i] = 8'h00;
    t_reset;
    t_addr_match;
    t_byte_write(9'h1A5, 8'h3C);
    t_random_read(9'h1A4, 3, "R4 byte write lands with bit 8");
    t_byte_write(9'h1FF, 8'hC3);
    t_byte_write(9'h000, 8'h5A);
    t_random_read(9'h1FF, 2, "R8 rollover 511 to 0");
    t_page_write;
    t_addr_only;
    t_restart_discard;
    t_midbyte_restart;
    t_nack_read;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule